// File: doc/BRIEF.md
# Secure Memory Split-Point Filter

This block guards on-chip memories such as a boot ROM and a system RAM. Each guarded memory (a zone) is divided at one programmable point: everything from the memory base up to the split is secure, and everything from the split to the memory top is non-secure. The split point is held in a per-zone size register, counted in 4 KiB pages. Software sets it over a simple 32-bit register bus and can freeze it with a lock bit that only a reset clears.

For every access the requester presents the zone, the byte offset within that memory and its security state. The block answers with a grant/deny flag computed combinationally from those inputs and the current register state. Secure requesters may reach any part of the memory. Non-secure requesters may reach only the part above the split. Register writes change the decision from the next clock onward.

Top module: `split_filter`

## Requirements
- R1: After reset each zone's size field equals that memory's full size in pages and its lock bit is clear. A read of a zone word returns the lock in bit 31, the size in bits [9:0] and zeros elsewhere.
- R2: Zone n's register sits at byte offset 4*n. A write to an offset that is not word aligned, or that maps to no zone, changes no register, and a read there returns 0.
- R3: A write with bit 31 high sets that zone's lock bit. Once set, the lock stays set until reset, and writing bit 31 low does not clear it.
- R4: While a zone is unlocked, a write loads bits [9:0] of the write data into its size field, visible on reads and in access decisions from the next clock. A write that sets the lock loads the size in the same write.
- R5: While a zone is locked, writes leave its size field unchanged.
- R6: A non-secure access (acc_secure=0) whose page index (offset >> 12) is below the zone's size is denied.
- R7: An access whose page index is at or above the size, but inside the memory, is granted to any requester. A secure access inside the memory is always granted.
- R8: A size of 0 makes the whole memory non-secure. A size at or above the memory's page count makes the whole memory secure.
- R9: An access at or beyond the memory top, or with a zone select of NUM_ZONES or more, is denied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| acc_zone | input | 2 | Zone selected by the access |
| acc_offset | input | 22 | Byte offset of the access within the memory |
| acc_secure | input | 1 | Requester is secure |
| acc_grant | output | 1 | Access is allowed |

## Verification
The bench builds the block with its default parameters: two zones of 24 and 64 pages, a 10-bit size field and a 2-bit zone select. With these values the memory top of each zone lies at a small offset, so the bench can reach the top boundary directly. The 2-bit select also leaves zone codes 2 and 3 unmapped, which puts the invalid-zone path within reach. The 10-bit field lets the bench write a size far beyond either memory and write zero, covering the all-secure and all-open extremes.

// File: rtl/split_filter_pkg.sv
package split_filter_pkg;
    localparam int REG_W     = 32;
    localparam int LOCK_POS  = 31;
    localparam int WORD_BITS = 2;

    function automatic logic [REG_W-1:0] pack_zone_word(input logic lock,
                                                        input logic [REG_W-2:0] size_ext);
        return {lock, size_ext};
    endfunction
endpackage

// File: rtl/split_zone_reg.sv
module split_zone_reg #(
    parameter int SIZE_W      = 10,
    parameter int RESET_PAGES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_lock,
    output logic [SIZE_W-1:0] size_q,
    output logic              lock_q
);
    typedef struct packed {
        logic              lock;
        logic [SIZE_W-1:0] size;
    } zstate_t;

    zstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            if (!st_q.lock) st_d.size = wr_size;
            if (wr_lock)    st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock <= 1'b0;
            st_q.size <= SIZE_W'(RESET_PAGES);
        end else begin
            st_q <= st_d;
        end
    end

    assign size_q = st_q.size;
    assign lock_q = st_q.lock;

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock);

    p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_lock) |=> st_q.lock);

    p_unlocked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !st_q.lock) |=> (st_q.size == $past(wr_size)));

    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable(st_q.size));
endmodule

// File: rtl/split_zone_check.sv
module split_zone_check #(
    parameter int OFF_W      = 22,
    parameter int SIZE_W     = 10,
    parameter int PAGE_SHIFT = 12,
    parameter int MEM_PAGES  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  offset,
    input  logic              secure,
    input  logic [SIZE_W-1:0] split_pages,
    output logic              grant
);
    localparam int PG_W = OFF_W - PAGE_SHIFT;

    logic [PG_W-1:0] page;
    logic            in_mem;
    logic            in_sec;

    always_comb begin
        page   = PG_W'(offset >> PAGE_SHIFT);
        in_mem = 32'(page) < 32'(MEM_PAGES);
        in_sec = 32'(page) < 32'(split_pages);
        grant  = in_mem && (secure || !in_sec);
    end

    p_nonsec_below_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!secure && (32'(offset >> PAGE_SHIFT) < 32'(split_pages))) |-> !grant);

    p_secure_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (secure && (32'(offset >> PAGE_SHIFT) < 32'(MEM_PAGES))) |-> grant);

    p_beyond_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(offset >> PAGE_SHIFT) >= 32'(MEM_PAGES)) |-> !grant);
endmodule

// File: rtl/split_filter.sv
module split_filter
    import split_filter_pkg::*;
#(
    parameter int                        NUM_ZONES  = 2,
    parameter int                        SIZE_W     = 10,
    parameter int                        PAGE_SHIFT = 12,
    parameter int                        OFF_W      = 22,
    parameter int                        ADDR_W     = 8,
    parameter logic [NUM_ZONES*SIZE_W-1:0] ZONE_PAGES = {10'd64, 10'd24},
    localparam int                       ZSEL_W     = $clog2(NUM_ZONES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [ZSEL_W-1:0] acc_zone,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic              acc_secure,
    output logic              acc_grant
);
    logic [NUM_ZONES-1:0] addr_hit;
    logic [NUM_ZONES-1:0] wr_hit;
    logic [NUM_ZONES-1:0] lock_vec;
    logic [NUM_ZONES-1:0] grant_vec;
    logic [SIZE_W-1:0]    size_vec [NUM_ZONES];
    logic                 word_ok;
    logic                 zone_ok;
    logic                 unused_wdata;

    assign unused_wdata = ^reg_wdata[LOCK_POS-1:SIZE_W];
    assign word_ok      = (reg_addr[WORD_BITS-1:0] == '0);

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        localparam int MEM_PG = int'(ZONE_PAGES[z*SIZE_W +: SIZE_W]);

        assign addr_hit[z] = word_ok && (int'(reg_addr >> WORD_BITS) == z);
        assign wr_hit[z]   = reg_we && addr_hit[z];

        split_zone_reg #(
            .SIZE_W      (SIZE_W),
            .RESET_PAGES (MEM_PG)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit[z]),
            .wr_size (reg_wdata[SIZE_W-1:0]),
            .wr_lock (reg_wdata[LOCK_POS]),
            .size_q  (size_vec[z]),
            .lock_q  (lock_vec[z])
        );

        split_zone_check #(
            .OFF_W      (OFF_W),
            .SIZE_W     (SIZE_W),
            .PAGE_SHIFT (PAGE_SHIFT),
            .MEM_PAGES  (MEM_PG)
        ) u_chk (
            .clk         (clk),
            .rst_n       (rst_n),
            .offset      (acc_offset),
            .secure      (acc_secure),
            .split_pages (size_vec[z]),
            .grant       (grant_vec[z])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (addr_hit[z])
                reg_rdata = pack_zone_word(lock_vec[z], (REG_W-1)'(size_vec[z]));
        end
    end

    always_comb begin
        zone_ok   = 1'b0;
        acc_grant = 1'b0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (int'(acc_zone) == z) begin
                zone_ok   = 1'b1;
                acc_grant = grant_vec[z];
            end
        end
    end

    p_bad_zone_denied_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_zone) >= NUM_ZONES) |-> !acc_grant);

    p_unmapped_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_ok || (int'(reg_addr >> WORD_BITS) >= NUM_ZONES)) |-> (reg_rdata == '0));

    p_grant_needs_zone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> zone_ok);
endmodule

// File: tb/split_filter_bench.sv
`timescale 1ns/1ps
module split_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  acc_zone = '0;
    logic [21:0] acc_offset = '0;
    logic        acc_secure = 1'b0;
    logic        acc_grant;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    split_filter u_split_filter (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_zone(acc_zone),
        .acc_offset(acc_offset), .acc_secure(acc_secure), .acc_grant(acc_grant)
    );

    typedef struct packed {
        logic [1:0]  zone;
        logic [21:0] off;
        logic        sec;
        logic        exp;
    } vec_t;

    // Reset state: zone 0 = 24 pages all secure, zone 1 = 64 pages all secure
    localparam vec_t VECS [8] = '{
        '{zone: 2'd0, off: 22'h000000, sec: 1'b1, exp: 1'b1},  // R7
        '{zone: 2'd0, off: 22'h000000, sec: 1'b0, exp: 1'b0},  // R6
        '{zone: 2'd0, off: 22'h017FFF, sec: 1'b0, exp: 1'b0},  // R6 R8
        '{zone: 2'd0, off: 22'h018000, sec: 1'b1, exp: 1'b0},  // R9 top
        '{zone: 2'd1, off: 22'h03FFFF, sec: 1'b0, exp: 1'b0},  // R8
        '{zone: 2'd1, off: 22'h03FFFF, sec: 1'b1, exp: 1'b1},  // R7
        '{zone: 2'd2, off: 22'h000000, sec: 1'b1, exp: 1'b0},  // R9 zone
        '{zone: 2'd3, off: 22'h000100, sec: 1'b1, exp: 1'b0}   // R9 zone
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic acc(input string req, input logic [1:0] z, input logic [21:0] o,
                       input logic s, input logic exp);
        acc_zone = z; acc_offset = o; acc_secure = s;
        #1;
        check(req, 32'(acc_grant), 32'(exp));
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 zone0 reset", 8'h00, 32'd24);
        rd("R1 zone1 reset", 8'h04, 32'd64);
        rd("R2 unmapped read", 8'h08, 32'd0);

        for (int i = 0; i < 8; i++)
            acc($sformatf("R6/R7/R8/R9 vector %0d", i), VECS[i].zone, VECS[i].off,
                VECS[i].sec, VECS[i].exp);

        // R4 unlocked write, R7 boundary
        wr(8'h00, 32'd4);
        rd("R4 zone0 size 4", 8'h00, 32'd4);
        acc("R6 last secure page", 2'd0, 22'h003FFF, 1'b0, 1'b0);
        acc("R7 first open page ns", 2'd0, 22'h004000, 1'b0, 1'b1);
        acc("R7 first open page s", 2'd0, 22'h004000, 1'b1, 1'b1);

        // R8 extremes
        wr(8'h00, 32'd0);
        acc("R8 size zero open", 2'd0, 22'h000000, 1'b0, 1'b1);
        acc("R9 top with size zero", 2'd0, 22'h018000, 1'b0, 1'b0);
        wr(8'h04, 32'h0000_FFFF);
        rd("R4 field truncated", 8'h04, 32'd1023);
        acc("R8 oversize secure", 2'd1, 22'h03FFFF, 1'b0, 1'b0);

        // R2 unmapped and misaligned writes
        wr(8'h08, 32'h8000_0007);
        wr(8'h01, 32'h8000_0005);
        rd("R2 zone0 untouched", 8'h00, 32'd0);
        rd("R2 zone1 untouched", 8'h04, 32'd1023);
        rd("R2 unmapped still zero", 8'h08, 32'd0);

        // R3/R4 lock with size, R5 hold
        wr(8'h04, 32'h8000_0010);
        rd("R3 lock set with size", 8'h04, 32'h8000_0010);
        wr(8'h04, 32'h0000_0002);
        rd("R3 R5 locked unchanged", 8'h04, 32'h8000_0010);
        acc("R5 split kept open", 2'd1, 22'h010000, 1'b0, 1'b1);
        acc("R5 split kept secure", 2'd1, 22'h00FFFF, 1'b0, 1'b0);
        wr(8'h00, 32'd5);
        rd("R3 other zone unlocked", 8'h00, 32'd5);

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 zone0 after reset", 8'h00, 32'd24);
        rd("R1 zone1 lock cleared", 8'h04, 32'd64);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule